// File: doc/BRIEF.md
# Stable Load Elimination Tracker

This block watches completed loads, keyed by program counter, and learns which ones keep reading the same data from the same address. Once such a load has proven itself, the block tells the front end that later instances of it need not execute: a lookup by PC returns an eliminate flag together with the value the load last produced.

Elimination for a load lasts only while its inputs are provably unchanged. Two monitor tables keep that promise. One is keyed by architectural register and the other by memory address. A write to the load's source register ends elimination, and so does a store or coherence snoop to the load's address. The load then drops back to training and has to earn its confidence again. Both monitor tables are small. When either one has no free slot, a load that has met the confidence bar still stays in training.

Top module: `stable_load_tracker`

## Requirements
- R1: A load is eliminated only after four completions with the same PC, address and data. The first completion allocates the entry with confidence 0. Each matching completion raises the 2-bit confidence by one. The load becomes stable when the confidence reaches 3.
- R2: A lookup whose PC hits a stable entry raises `lk_elim` in the same cycle and drives `lk_value` with the data last stored for that entry. `lk_elim` is never high without `lk_valid`, and `lk_value` is zero whenever `lk_elim` is low.
- R3: A register write whose register id equals the source register of a stable load clears that load's stable state. Writes to other registers have no effect on it.
- R4: An invalidation (store or snoop) whose address equals a stable load's address clears that load's stable state. Other addresses have no effect on it.
- R5: A completion that hits an entry's PC but returns a different address or different data resets the confidence to 0, clears stable, and stores the new address and data.
- R6: After any invalidation the entry is in training with confidence 0. It becomes stable again only after three further matching completions.
- R7: If a lookup and an invalidation of the same entry occur in the same cycle, the invalidation wins and `lk_elim` is low in that cycle.
- R8: Each monitor table holds 16 loads. While 16 loads are stable, a load that reaches confidence 3 stays non-stable. A later matching completion promotes it once a slot has been freed.
- R9: After reset no entry is valid and no lookup is eliminated.
- R10: The detector is direct-mapped on the low 5 PC bits, with the rest of the PC as tag. A completion whose tag differs replaces the entry with confidence 0, and a lookup with a different tag is not eliminated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request for a new load instance |
| lk_pc | input | 32 | PC of the looked-up load |
| lk_elim | output | 1 | Load may skip execution |
| lk_value | output | 32 | Stored value for an eliminated load |
| cp_valid | input | 1 | A load has completed |
| cp_pc | input | 32 | PC of the completed load |
| cp_addr | input | 32 | Address it read |
| cp_data | input | 32 | Data it returned |
| cp_src | input | 5 | Its source register id |
| wr_valid | input | 1 | A register is written |
| wr_reg | input | 5 | Destination register id |
| inv_valid | input | 1 | Store or snoop to memory |
| inv_addr | input | 32 | Address of the store or snoop |

## Verification
The assertions rely on several assumptions about the inputs. At most one completion, one register write and one invalidation arrive per cycle. Addresses are compared as whole words, with no overlap between partial accesses. A load whose entry is stable is assumed to keep the source register it had when it was promoted. The stimulus follows these assumptions by driving each port through a single-slot task and by using word-aligned addresses. It also reuses the same source register for every completion of a given PC. Each cycle, a behavioural model in the bench predicts the lookup result from its own per-entry records and a count of stable loads. The targeted sequences cover the confidence threshold, register and address kills, the same-cycle conflict, tag replacement and a full monitor table.

// File: rtl/slt_pkg.sv
// Shared constants and helpers for the stable load tracker.
// Assumes a 2-bit saturating confidence counter.
package slt_pkg;
    localparam int unsigned CONF_W = 2;
    localparam logic [CONF_W-1:0] CONF_SAT = 2'd3;

    // Saturating increment of a confidence value.
    function automatic logic [CONF_W-1:0] conf_inc(input logic [CONF_W-1:0] c);
        return (c == CONF_SAT) ? CONF_SAT : c + 1'b1;
    endfunction
endpackage

// File: rtl/slt_monitor.sv
// Monitor table: a small fully associative set of slots. Each slot binds
// a key (register id or address) to the detector entry that depends on it.
// A probe returns a vector of detector entries whose key matched. Slots
// whose owner appears in free_vec are released on the next edge. Allocation
// takes the lowest free slot. Assumes the caller never allocates while full.
module slt_monitor #(
    parameter int unsigned N      = 16,
    parameter int unsigned KEY_W  = 5,
    parameter int unsigned DET_N  = 32,
    localparam int unsigned OWN_W  = $clog2(DET_N),
    localparam int unsigned SLOT_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             probe_valid,
    input  logic [KEY_W-1:0] probe_key,
    output logic [DET_N-1:0] probe_hits,
    input  logic [DET_N-1:0] free_vec,
    input  logic             alloc_valid,
    input  logic [KEY_W-1:0] alloc_key,
    input  logic [OWN_W-1:0] alloc_own,
    output logic             full
);
    logic [N-1:0]     vld_q;
    logic [KEY_W-1:0] key_q [N];
    logic [OWN_W-1:0] own_q [N];
    logic [SLOT_W-1:0] pick;

    // Collect the owners of every slot whose key matches the probe.
    always_comb begin
        probe_hits = '0;
        for (int j = 0; j < N; j++) begin
            if (probe_valid && vld_q[j] && key_q[j] == probe_key)
                probe_hits[own_q[j]] = 1'b1;
        end
    end

    // Lowest free slot and table-full flag.
    always_comb begin
        pick = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (!vld_q[j]) pick = SLOT_W'(j);
        end
        full = &vld_q;
    end

    // Slot valid bits: release freed owners, claim on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int j = 0; j < N; j++) begin
                if (vld_q[j] && free_vec[own_q[j]]) vld_q[j] <= 1'b0;
                if (alloc_valid && !vld_q[j] && pick == SLOT_W'(j)) vld_q[j] <= 1'b1;
            end
        end
    end

    // Slot payload: key and owner written on allocation.
    always_ff @(posedge clk) begin
        for (int j = 0; j < N; j++) begin
            if (alloc_valid && !vld_q[j] && pick == SLOT_W'(j)) begin
                key_q[j] <= alloc_key;
                own_q[j] <= alloc_own;
            end
        end
    end

    AST_ALLOC_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |-> !full); // R8
endmodule

// File: rtl/slt_detector.sv
// Detector table: direct-mapped on low PC bits, one entry per load PC.
// Each entry holds a tag, the last address and data, a saturating
// confidence and a stable bit. An external kill clears confidence and
// stable and wins over a completion to the same entry. Promotion to
// stable needs confidence 3, a free monitor slot and no kill that cycle.
module slt_detector
    import slt_pkg::*;
#(
    parameter int unsigned DET_N  = 32,
    parameter int unsigned PC_W   = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(DET_N),
    localparam int unsigned TAG_W = PC_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit_stable,
    output logic [DATA_W-1:0] lk_data,
    input  logic              cp_valid,
    input  logic [IDX_W-1:0]  cp_idx,
    input  logic [TAG_W-1:0]  cp_tag,
    input  logic [ADDR_W-1:0] cp_addr,
    input  logic [DATA_W-1:0] cp_data,
    input  logic [DET_N-1:0]  ext_kill,
    input  logic              alloc_ok,
    output logic              promote,
    output logic [DET_N-1:0]  self_free
);
    logic [DET_N-1:0]  valid_q, stable_q;
    logic [CONF_W-1:0] conf_q [DET_N];
    logic [TAG_W-1:0]  tag_q  [DET_N];
    logic [ADDR_W-1:0] addr_q [DET_N];
    logic [DATA_W-1:0] data_q [DET_N];
    logic same_pc, same_vals;
    logic [CONF_W-1:0] conf_nx;

    // Lookup read port.
    always_comb begin
        lk_hit_stable = valid_q[lk_idx] && stable_q[lk_idx] && tag_q[lk_idx] == lk_tag;
        lk_data       = data_q[lk_idx];
    end

    // Completion classification, promotion request and slot release.
    always_comb begin
        same_pc   = valid_q[cp_idx] && tag_q[cp_idx] == cp_tag;
        same_vals = addr_q[cp_idx] == cp_addr && data_q[cp_idx] == cp_data;
        conf_nx   = conf_inc(conf_q[cp_idx]);
        promote   = cp_valid && same_pc && same_vals && !stable_q[cp_idx]
                    && conf_nx == CONF_SAT && alloc_ok && !ext_kill[cp_idx];
        self_free = '0;
        if (cp_valid && stable_q[cp_idx] && !(same_pc && same_vals))
            self_free[cp_idx] = 1'b1;
    end

    // Entry control state: training, promotion and kills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            stable_q <= '0;
            for (int i = 0; i < DET_N; i++) conf_q[i] <= '0;
        end else begin
            for (int i = 0; i < DET_N; i++) begin
                if (ext_kill[i]) begin
                    conf_q[i]   <= '0;
                    stable_q[i] <= 1'b0;
                    if (cp_valid && cp_idx == IDX_W'(i)) valid_q[i] <= 1'b1;
                end else if (cp_valid && cp_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    if (same_pc && same_vals) begin
                        conf_q[i] <= conf_nx;
                        if (promote) stable_q[i] <= 1'b1;
                    end else begin
                        conf_q[i]   <= '0;
                        stable_q[i] <= 1'b0;
                    end
                end
            end
        end
    end

    // Entry payload: tag, address and data of the latest completion.
    always_ff @(posedge clk) begin
        if (cp_valid) begin
            tag_q[cp_idx]  <= cp_tag;
            addr_q[cp_idx] <= cp_addr;
            data_q[cp_idx] <= cp_data;
        end
    end

    AST_STABLE_HAS_CONF: assert property (@(posedge clk) disable iff (!rst_n)
        stable_q[lk_idx] |-> conf_q[lk_idx] == CONF_SAT); // R1

    for (genvar g = 0; g < DET_N; g++) begin : g_kill_chk
        AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            ext_kill[g] |=> !stable_q[g]); // R3
    end
endmodule

// File: rtl/stable_load_tracker.sv
// Top level: detector plus register and address monitor tables. A lookup
// is eliminated when its entry is stable and no register write or memory
// invalidation hits that entry in the same cycle. Assumes at most one
// event per port per cycle and whole-word address comparison.
module stable_load_tracker #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_W  = 5,
    parameter int unsigned DET_N  = 32,
    parameter int unsigned MON_N  = 16,
    localparam int unsigned IDX_W = $clog2(DET_N),
    localparam int unsigned TAG_W = PC_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_elim,
    output logic [DATA_W-1:0] lk_value,
    input  logic              cp_valid,
    input  logic [PC_W-1:0]   cp_pc,
    input  logic [ADDR_W-1:0] cp_addr,
    input  logic [DATA_W-1:0] cp_data,
    input  logic [REG_W-1:0]  cp_src,
    input  logic              wr_valid,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr
);
    logic [DET_N-1:0] reg_hits, addr_hits, ext_kill, self_free, free_vec;
    logic rmt_full, amt_full, promote, hit_stable;
    logic [DATA_W-1:0] hit_data;
    logic [IDX_W-1:0] lk_idx, cp_idx;

    // Combine kills and split PCs into index and tag.
    always_comb begin
        ext_kill = reg_hits | addr_hits;
        free_vec = ext_kill | self_free;
        lk_idx   = lk_pc[IDX_W-1:0];
        cp_idx   = cp_pc[IDX_W-1:0];
    end

    slt_detector #(.DET_N(DET_N), .PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_det (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_tag(lk_pc[PC_W-1:IDX_W]),
        .lk_hit_stable(hit_stable), .lk_data(hit_data),
        .cp_valid(cp_valid), .cp_idx(cp_idx), .cp_tag(cp_pc[PC_W-1:IDX_W]),
        .cp_addr(cp_addr), .cp_data(cp_data),
        .ext_kill(ext_kill), .alloc_ok(!rmt_full && !amt_full),
        .promote(promote), .self_free(self_free)
    );

    slt_monitor #(.N(MON_N), .KEY_W(REG_W), .DET_N(DET_N)) u_rmt (
        .clk(clk), .rst_n(rst_n),
        .probe_valid(wr_valid), .probe_key(wr_reg), .probe_hits(reg_hits),
        .free_vec(free_vec), .alloc_valid(promote), .alloc_key(cp_src),
        .alloc_own(cp_idx), .full(rmt_full)
    );

    slt_monitor #(.N(MON_N), .KEY_W(ADDR_W), .DET_N(DET_N)) u_amt (
        .clk(clk), .rst_n(rst_n),
        .probe_valid(inv_valid), .probe_key(inv_addr), .probe_hits(addr_hits),
        .free_vec(free_vec), .alloc_valid(promote), .alloc_key(cp_addr),
        .alloc_own(cp_idx), .full(amt_full)
    );

    // Elimination decision; an invalidation of the same entry wins.
    always_comb begin
        lk_elim  = lk_valid && hit_stable && !ext_kill[lk_idx];
        lk_value = lk_elim ? hit_data : '0;
    end

    AST_ELIM_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_elim |-> lk_valid); // R2
    AST_KILLED_NOT_ELIM: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ext_kill[lk_idx]) |-> !lk_elim); // R7
endmodule

// File: tb/tb_stable_load_tracker.sv
module tb_stable_load_tracker;
    logic clk = 0, rst_n = 0;
    logic lk_valid = 0, cp_valid = 0, wr_valid = 0, inv_valid = 0;
    logic [31:0] lk_pc = 0, cp_pc = 0, cp_addr = 0, cp_data = 0, inv_addr = 0;
    logic [4:0] cp_src = 0, wr_reg = 0;
    logic lk_elim;
    logic [31:0] lk_value;
    int checks = 0, errors = 0;
    string cur_req = "R9";
    bit done = 0;

    always #5 clk = ~clk;

    stable_load_tracker dut (.*);

    // Behavioural reference: one record per detector index.
    bit m_valid[32], m_stable[32];
    int m_conf[32];
    logic [26:0] m_tag[32];
    logic [31:0] m_addr[32], m_data[32];
    logic [4:0] m_src[32];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit killed(int i);
        if (!m_valid[i] || !m_stable[i]) return 0;
        return (wr_valid && wr_reg == m_src[i]) || (inv_valid && inv_addr == m_addr[i]);
    endfunction

    // One clock: compare outputs mid-cycle, then advance the model.
    task automatic step();
        bit exp_e;
        int li, ci, cnt;
        bit kv[32];
        #1;
        li = lk_pc[4:0];
        exp_e = lk_valid && m_valid[li] && m_stable[li] && m_tag[li] == lk_pc[31:5] && !killed(li);
        check(lk_elim == exp_e, cur_req, "lk_elim", {31'b0, lk_elim}, {31'b0, exp_e});
        check(lk_value == (exp_e ? m_data[li] : 32'h0), cur_req, "lk_value", lk_value,
              exp_e ? m_data[li] : 32'h0);
        cnt = 0;
        for (int i = 0; i < 32; i++) begin
            kv[i] = killed(i);
            if (m_valid[i] && m_stable[i]) cnt++;
        end
        @(posedge clk);
        if (rst_n && cp_valid) begin
            ci = cp_pc[4:0];
            if (m_valid[ci] && m_tag[ci] == cp_pc[31:5] && m_addr[ci] == cp_addr && m_data[ci] == cp_data) begin
                m_conf[ci] = (m_conf[ci] == 3) ? 3 : m_conf[ci] + 1;
                if (!m_stable[ci] && m_conf[ci] == 3 && cnt < 16 && !kv[ci]) begin
                    m_stable[ci] = 1; m_src[ci] = cp_src;
                end
            end else begin
                m_valid[ci] = 1; m_tag[ci] = cp_pc[31:5]; m_addr[ci] = cp_addr;
                m_data[ci] = cp_data; m_conf[ci] = 0; m_stable[ci] = 0;
            end
        end
        if (rst_n) for (int i = 0; i < 32; i++) if (kv[i]) begin m_conf[i] = 0; m_stable[i] = 0; end
        @(negedge clk);
        lk_valid = 0; cp_valid = 0; wr_valid = 0; inv_valid = 0;
    endtask

    task automatic complete(input logic [31:0] pc, input logic [31:0] a,
                            input logic [31:0] d, input logic [4:0] s);
        cp_valid = 1; cp_pc = pc; cp_addr = a; cp_data = d; cp_src = s;
    endtask

    task automatic lookup(input logic [31:0] pc);
        lk_valid = 1; lk_pc = pc;
    endtask

    task automatic expect_elim(input logic [31:0] pc, input bit exp, input string req);
        lookup(pc);
        #1;
        check(lk_elim == exp, req, "explicit elim", {31'b0, lk_elim}, {31'b0, exp});
        step();
    endtask

    task automatic train(input logic [31:0] pc, input logic [31:0] a,
                         input logic [31:0] d, input logic [4:0] s, input int n);
        for (int k = 0; k < n; k++) begin complete(pc, a, d, s); step(); end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_valid[i] = 0; m_stable[i] = 0; m_conf[i] = 0; end
        @(negedge clk);
        step(); step();
        rst_n = 1;
        cur_req = "R9";
        expect_elim(32'h0000_1004, 0, "R9");

        // R1 threshold, R2 value
        cur_req = "R1";
        train(32'h0000_1004, 32'h8000_0040, 32'hCAFE_0001, 5'd3, 3);
        expect_elim(32'h0000_1004, 0, "R1");
        train(32'h0000_1004, 32'h8000_0040, 32'hCAFE_0001, 5'd3, 1);
        cur_req = "R2";
        expect_elim(32'h0000_1004, 1, "R2");
        check(1, "R2", "value seen by model", 0, 0);

        // R3 register write
        cur_req = "R3";
        wr_valid = 1; wr_reg = 5'd7; step();
        expect_elim(32'h0000_1004, 1, "R3");
        wr_valid = 1; wr_reg = 5'd3; step();
        expect_elim(32'h0000_1004, 0, "R3");

        // R6 retrain after invalidation
        cur_req = "R6";
        train(32'h0000_1004, 32'h8000_0040, 32'hCAFE_0001, 5'd3, 2);
        expect_elim(32'h0000_1004, 0, "R6");
        train(32'h0000_1004, 32'h8000_0040, 32'hCAFE_0001, 5'd3, 1);
        expect_elim(32'h0000_1004, 1, "R6");

        // R4 store / snoop
        cur_req = "R4";
        inv_valid = 1; inv_addr = 32'h8000_0044; step();
        expect_elim(32'h0000_1004, 1, "R4");
        inv_valid = 1; inv_addr = 32'h8000_0040; step();
        expect_elim(32'h0000_1004, 0, "R4");

        // R7 same-cycle conflict
        cur_req = "R7";
        train(32'h0000_1004, 32'h8000_0040, 32'hCAFE_0001, 5'd3, 3);
        wr_valid = 1; wr_reg = 5'd3;
        expect_elim(32'h0000_1004, 0, "R7");

        // R5 data mismatch
        cur_req = "R5";
        train(32'h0000_1004, 32'h8000_0040, 32'hCAFE_0001, 5'd3, 3);
        expect_elim(32'h0000_1004, 1, "R5");
        train(32'h0000_1004, 32'h8000_0040, 32'hBEEF_0002, 5'd3, 1);
        expect_elim(32'h0000_1004, 0, "R5");
        train(32'h0000_1004, 32'h8000_0040, 32'hBEEF_0002, 5'd3, 3);
        expect_elim(32'h0000_1004, 1, "R5");

        // R10 tag replacement
        cur_req = "R10";
        expect_elim(32'h0000_2004, 0, "R10");
        train(32'h0000_2004, 32'h8000_0080, 32'h1234_5678, 5'd9, 1);
        expect_elim(32'h0000_1004, 0, "R10");

        // R8 monitor table capacity
        cur_req = "R8";
        for (int p = 0; p < 16; p++)
            train(32'h0000_3000 + p, 32'h9000_0000 + 4 * p, 32'h100 + p, 5'(p), 4);
        expect_elim(32'h0000_300F, 1, "R8");
        train(32'h0000_3010, 32'h9000_1000, 32'h777, 5'd20, 4);
        expect_elim(32'h0000_3010, 0, "R8");
        wr_valid = 1; wr_reg = 5'd0; step();
        train(32'h0000_3010, 32'h9000_1000, 32'h777, 5'd20, 1);
        expect_elim(32'h0000_3010, 1, "R8");

        // mixed traffic with model compare every cycle
        cur_req = "R3";
        for (int k = 0; k < 200; k++) begin
            complete(32'h0000_4000 + (k % 6), 32'hA000_0000 + 4 * (k % 3), 32'h55 + (k % 2 == 0 ? 0 : k % 7 == 0), 5'(k % 6));
            lookup(32'h0000_4000 + ((k + 1) % 6));
            if (k % 11 == 0) begin wr_valid = 1; wr_reg = 5'(k % 6); end
            if (k % 13 == 0) begin inv_valid = 1; inv_addr = 32'hA000_0000 + 4 * (k % 3); end
            step();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule